// File: doc/BRIEF.md
# Image Resize Coefficient Calculator

This block works out the scaler settings for a two-axis image resize. A single start pulse hands it the source and target sizes for the vertical and horizontal axes. Each axis is handled in two steps. First a bounded power-of-two pre-decimation shift is chosen. Then a 14-bit fixed-point step ratio is computed, scaled by 2^13, from the decimated source size and the target size.

The vertical axis is handled first and the horizontal axis second. Both share one restoring divider that produces one quotient bit per clock. When both axes are legal, the two results are packed into a 32-bit control word that the resize datapath decodes. An illegal request on either axis raises an error flag and leaves the word at zero. A ratio that does not fit in 14 bits is clamped to its maximum and reported as a warning.

Sizes are captured when start is accepted. A start that arrives while a computation is running is ignored. Completion is marked by a one-cycle done pulse.

Top module: `rsz_coef_calc`

## Requirements
- R1: A request is illegal if any source size is above 4096 or any target size is above 1024. An illegal request sets err and clears word_ok.
- R2: A request is illegal if four times the target size is smaller than the source size, so shrinking by more than 4:1 is refused.
- R3: A request is illegal if a target size is below 2 or a source size is 0. A target size of exactly 2 is legal.
- R4: The shift count starts at 0. The working size is halved and the count incremented while the working size is above 1024 or at least twice the target size. The count never exceeds 2.
- R5: The ratio equals floor(8192 × (working size − 1) / (target size − 1)).
- R6: A ratio of 16384 or more is replaced by 0x3FFF. In that case ovf is set. ovf reports a clamp on any axis whose ratio was computed.
- R7: The vertical shift count goes in rsz_word[31:30] and the vertical ratio in [29:16]. The horizontal shift count goes in [15:14] and the horizontal ratio in [13:0].
- R8: If either axis is illegal, rsz_word stays 0 and word_ok stays low. err and word_ok are never high together.
- R9: done is high for exactly one cycle when the computation ends. busy is high from the cycle after start is accepted until done. After done, busy falls.
- R10: A start pulse seen while busy is ignored. Sizes are captured only on the start that is accepted.
- R11: After reset, busy, done, word_ok, err, ovf and rsz_word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation when idle |
| v_in_size | input | 13 | Vertical source size |
| v_out_size | input | 13 | Vertical target size |
| h_in_size | input | 13 | Horizontal source size |
| h_out_size | input | 13 | Horizontal target size |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| word_ok | output | 1 | rsz_word holds a valid result |
| err | output | 1 | Request was illegal |
| ovf | output | 1 | A ratio was clamped to 0x3FFF |
| rsz_word | output | 32 | Packed shift counts and ratios |

## Verification
Some properties are checked on every cycle:
- done is a single-cycle pulse, and busy falls after it;
- busy only rises after a start;
- err and word_ok are never high together;
- a failed request leaves the word at zero;
- a clamped ratio shows up as 0x3FFF in one of the two ratio fields;
- the word holds while idle.

Other properties can only be shown by the directed scenarios:
- the arithmetic values (shift count choice, floor division, the 4:1 and size limits and their exact boundaries);
- the field packing;
- that a start pulsed mid-run does not change the result.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_DIV   = 2'd2,
    ST_FIN   = 2'd3
  } rsz_state_e;
endpackage

// File: rtl/rsz_axis_prep.sv
// Legality check and pre-decimation shift selection for one axis.
module rsz_axis_prep #(
  parameter int SIZE_W  = 13,
  parameter int MAX_IN  = 4096,
  parameter int MAX_OUT = 1024,
  parameter int DN_W    = 2,
  parameter int DN_MAX  = 2
) (
  input  logic [SIZE_W-1:0] in_sz,
  input  logic [SIZE_W-1:0] out_sz,
  output logic              bad,
  output logic [DN_W-1:0]   dn,
  output logic [SIZE_W-1:0] ws_m1
);
  localparam logic [SIZE_W-1:0] LIM_IN  = SIZE_W'(MAX_IN);
  localparam logic [SIZE_W-1:0] LIM_OUT = SIZE_W'(MAX_OUT);

  logic [SIZE_W+1:0] out_x4;
  logic [SIZE_W:0]   out_x2;

  always_comb begin
    out_x4 = {out_sz, 2'b00};
    bad = (in_sz > LIM_IN) || (out_sz > LIM_OUT) ||
          (out_x4 < {2'b00, in_sz}) ||
          (out_sz < SIZE_W'(2)) || (in_sz == '0);
  end

  assign out_x2 = {out_sz, 1'b0};

  // Unrolled halving chain; once a stage stops shrinking, all later ones do too.
  logic [DN_MAX:0][SIZE_W-1:0] ws_chain;
  logic [DN_MAX:0][DN_W-1:0]   cnt_chain;

  assign ws_chain[0]  = in_sz;
  assign cnt_chain[0] = '0;

  for (genvar g = 0; g < DN_MAX; g++) begin : g_stage
    logic shrink;
    assign shrink = (ws_chain[g] > LIM_OUT) || ({1'b0, ws_chain[g]} >= out_x2);
    assign ws_chain[g+1]  = shrink ? (ws_chain[g] >> 1) : ws_chain[g];
    assign cnt_chain[g+1] = shrink ? (cnt_chain[g] + DN_W'(1)) : cnt_chain[g];
  end

  assign dn    = cnt_chain[DN_MAX];
  assign ws_m1 = ws_chain[DN_MAX] - SIZE_W'(1);
endmodule

// File: rtl/rsz_divider.sv
// Restoring divider, one quotient bit per clock.
module rsz_divider #(
  parameter int DVD_W = 26,
  parameter int DVS_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] q_q, q_n;
  logic [DVS_W-1:0] rem_q, rem_n;
  logic [DVS_W-1:0] dvs_q, dvs_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic [DVS_W:0]   trial;
  logic             fits;

  always_comb begin
    trial = {rem_q, q_q[DVD_W-1]};
    fits  = trial >= {1'b0, dvs_q};
    q_n    = q_q;
    rem_n  = rem_q;
    dvs_n  = dvs_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (go) begin
      q_n   = dividend;
      rem_n = '0;
      dvs_n = divisor;
      cnt_n = CNT_W'(DVD_W);
    end else if (cnt_q != '0) begin
      rem_n  = fits ? DVS_W'(trial - {1'b0, dvs_q}) : DVS_W'(trial);
      q_n    = {q_q[DVD_W-2:0], fits};
      cnt_n  = cnt_q - CNT_W'(1);
      done_n = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      q_q    <= q_n;
      rem_q  <= rem_n;
      dvs_q  <= dvs_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign done     = done_q;
  assign quotient = q_q;
endmodule

// File: rtl/rsz_ctrl.sv
// Sequencer: captures sizes, runs vertical then horizontal, packs the word.
module rsz_ctrl
  import rsz_pkg::*;
#(
  parameter int SIZE_W = 13,
  parameter int FRAC_W = 13,
  parameter int COEF_W = 14,
  parameter int DN_W   = 2,
  parameter int DVD_W  = SIZE_W + FRAC_W,
  parameter int WORD_W = 2 * (DN_W + COEF_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] v_in,
  input  logic [SIZE_W-1:0] v_out,
  input  logic [SIZE_W-1:0] h_in,
  input  logic [SIZE_W-1:0] h_out,
  output logic [SIZE_W-1:0] cur_in,
  output logic [SIZE_W-1:0] cur_out,
  input  logic              prep_bad,
  input  logic [DN_W-1:0]   prep_dn,
  input  logic [SIZE_W-1:0] prep_ws_m1,
  output logic              div_go,
  output logic [DVD_W-1:0]  div_dvd,
  output logic [SIZE_W-1:0] div_dvs,
  input  logic              div_done,
  input  logic [DVD_W-1:0]  div_q,
  output logic              busy,
  output logic              done,
  output logic              word_ok,
  output logic              err,
  output logic              ovf,
  output logic [WORD_W-1:0] word
);
  rsz_state_e st_q, st_n;
  logic              axis_h_q, axis_h_n;
  logic [SIZE_W-1:0] vi_q, vi_n, vo_q, vo_n, hi_q, hi_n, ho_q, ho_n;
  logic [DN_W-1:0]   vdn_q, vdn_n;
  logic [COEF_W-1:0] vcf_q, vcf_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              ok_q, ok_n, err_q, err_n, ovf_q, ovf_n;
  logic              sat;
  logic [COEF_W-1:0] coef;

  assign cur_in  = axis_h_q ? hi_q : vi_q;
  assign cur_out = axis_h_q ? ho_q : vo_q;
  assign div_dvd = {prep_ws_m1, {FRAC_W{1'b0}}};
  assign div_dvs = cur_out - SIZE_W'(1);

  // Clamp quotient to the ratio width.
  always_comb begin
    sat  = |div_q[DVD_W-1:COEF_W];
    coef = sat ? {COEF_W{1'b1}} : div_q[COEF_W-1:0];
  end

  always_comb begin
    st_n     = st_q;
    axis_h_n = axis_h_q;
    vi_n = vi_q; vo_n = vo_q; hi_n = hi_q; ho_n = ho_q;
    vdn_n  = vdn_q;
    vcf_n  = vcf_q;
    word_n = word_q;
    ok_n   = ok_q;
    err_n  = err_q;
    ovf_n  = ovf_q;
    div_go = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          vi_n = v_in; vo_n = v_out; hi_n = h_in; ho_n = h_out;
          axis_h_n = 1'b0;
          word_n = '0;
          ok_n   = 1'b0;
          err_n  = 1'b0;
          ovf_n  = 1'b0;
          st_n   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (prep_bad) begin
          err_n = 1'b1;
          st_n  = ST_FIN;
        end else begin
          div_go = 1'b1;
          st_n   = ST_DIV;
        end
      end
      ST_DIV: begin
        if (div_done) begin
          ovf_n = ovf_q | sat;
          if (!axis_h_q) begin
            vdn_n    = prep_dn;
            vcf_n    = coef;
            axis_h_n = 1'b1;
            st_n     = ST_CHECK;
          end else begin
            word_n = {vdn_q, vcf_q, prep_dn, coef};
            ok_n   = 1'b1;
            st_n   = ST_FIN;
          end
        end
      end
      ST_FIN: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      axis_h_q <= 1'b0;
      vi_q <= '0; vo_q <= '0; hi_q <= '0; ho_q <= '0;
      vdn_q  <= '0;
      vcf_q  <= '0;
      word_q <= '0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      st_q     <= st_n;
      axis_h_q <= axis_h_n;
      vi_q <= vi_n; vo_q <= vo_n; hi_q <= hi_n; ho_q <= ho_n;
      vdn_q  <= vdn_n;
      vcf_q  <= vcf_n;
      word_q <= word_n;
      ok_q   <= ok_n;
      err_q  <= err_n;
      ovf_q  <= ovf_n;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = (st_q == ST_FIN);
  assign word_ok = ok_q;
  assign err     = err_q;
  assign ovf     = ovf_q;
  assign word    = word_q;
endmodule

// File: rtl/rsz_coef_calc.sv
module rsz_coef_calc #(
  parameter int SIZE_W  = 13,
  parameter int MAX_IN  = 4096,
  parameter int MAX_OUT = 1024,
  parameter int FRAC_W  = 13,
  parameter int COEF_W  = 14,
  parameter int DN_W    = 2,
  parameter int DN_MAX  = 2,
  parameter int WORD_W  = 2 * (DN_W + COEF_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] v_in_size,
  input  logic [SIZE_W-1:0] v_out_size,
  input  logic [SIZE_W-1:0] h_in_size,
  input  logic [SIZE_W-1:0] h_out_size,
  output logic              busy,
  output logic              done,
  output logic              word_ok,
  output logic              err,
  output logic              ovf,
  output logic [WORD_W-1:0] rsz_word
);
  localparam int DVD_W = SIZE_W + FRAC_W;

  logic [SIZE_W-1:0] cur_in, cur_out, prep_ws_m1, div_dvs;
  logic              prep_bad, div_go, div_done;
  logic [DN_W-1:0]   prep_dn;
  logic [DVD_W-1:0]  div_dvd, div_q;

  rsz_axis_prep #(
    .SIZE_W(SIZE_W), .MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT),
    .DN_W(DN_W), .DN_MAX(DN_MAX)
  ) u_prep (
    .in_sz(cur_in), .out_sz(cur_out),
    .bad(prep_bad), .dn(prep_dn), .ws_m1(prep_ws_m1)
  );

  rsz_divider #(.DVD_W(DVD_W), .DVS_W(SIZE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(div_dvd), .divisor(div_dvs),
    .done(div_done), .quotient(div_q)
  );

  rsz_ctrl #(
    .SIZE_W(SIZE_W), .FRAC_W(FRAC_W), .COEF_W(COEF_W),
    .DN_W(DN_W), .DVD_W(DVD_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .v_in(v_in_size), .v_out(v_out_size),
    .h_in(h_in_size), .h_out(h_out_size),
    .cur_in(cur_in), .cur_out(cur_out),
    .prep_bad(prep_bad), .prep_dn(prep_dn), .prep_ws_m1(prep_ws_m1),
    .div_go(div_go), .div_dvd(div_dvd), .div_dvs(div_dvs),
    .div_done(div_done), .div_q(div_q),
    .busy(busy), .done(done), .word_ok(word_ok),
    .err(err), .ovf(ovf), .word(rsz_word)
  );
endmodule

// File: rtl/rsz_coef_calc_chk.sv
module rsz_coef_calc_chk #(
  parameter int COEF_W = 14,
  parameter int DN_W   = 2,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              word_ok,
  input logic              err,
  input logic              ovf,
  input logic [WORD_W-1:0] rsz_word
);
  localparam int HALF = DN_W + COEF_W;

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r9_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r8_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(word_ok && err));
  a_r8_zero_word_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rsz_word == '0));
  a_r6_clamp_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf && word_ok) |->
      ((rsz_word[COEF_W-1:0] == {COEF_W{1'b1}}) ||
       (rsz_word[HALF+COEF_W-1:HALF] == {COEF_W{1'b1}})));
  a_r10_word_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(rsz_word));
endmodule

bind rsz_coef_calc rsz_coef_calc_chk #(
  .COEF_W(COEF_W), .DN_W(DN_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .word_ok(word_ok), .err(err), .ovf(ovf), .rsz_word(rsz_word)
);

// File: tb/rsz_coef_calc_bench.sv
module rsz_coef_calc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 13;
  localparam int WATCHDOG = 200000;

  logic clk, rst_n, start;
  logic [SW-1:0] v_in, v_out, h_in, h_out;
  logic busy, done, word_ok, err, ovf;
  logic [31:0] rsz_word;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  rsz_coef_calc u_rsz_coef_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .v_in_size(v_in), .v_out_size(v_out),
    .h_in_size(h_in), .h_out_size(h_out),
    .busy(busy), .done(done), .word_ok(word_ok),
    .err(err), .ovf(ovf), .rsz_word(rsz_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Independent model of one axis, derived from R1..R6.
  task automatic model_axis(input int si, input int so, output bit bad,
                            output int dn, output int coef, output bit sat);
    longint c;
    int ws;
    bad = (si > 4096) || (so > 1024) || (so * 4 < si) || (so < 2) || (si < 1);
    dn = 0; coef = 0; sat = 0;
    if (!bad) begin
      ws = si;
      while (((ws > 1024) || (ws >= 2 * so)) && (dn < 2)) begin
        ws = ws >> 1;
        dn++;
      end
      c = (64'(8192) * longint'(ws - 1)) / longint'(so - 1);
      if (c >= 16384) begin
        c = 16383;
        sat = 1;
      end
      coef = int'(c);
    end
  endtask

  task automatic expect_all(input int vi, input int vo, input int hi, input int ho,
                            output longint ew, output bit eok, output bit eerr, output bit eovf);
    bit vb, hb, vs, hs;
    int vd, vc, hd, hc;
    ew = 0; eok = 0; eerr = 0; eovf = 0;
    model_axis(vi, vo, vb, vd, vc, vs);
    if (vb) begin
      eerr = 1;
    end else begin
      eovf = vs;
      model_axis(hi, ho, hb, hd, hc, hs);
      if (hb) eerr = 1;
      else begin
        eovf = vs | hs;
        eok = 1;
        ew = (longint'(vd) << 30) | (longint'(vc) << 16) | (longint'(hd) << 14) | longint'(hc);
      end
    end
  endtask

  task automatic wait_done(input string req);
    int guard = 0;
    while (!done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk({req, " done seen"}, longint'(done), 1);
  endtask

  task automatic run_case(input string req, input int vi, input int vo, input int hi, input int ho);
    longint ew;
    bit eok, eerr, eovf;
    expect_all(vi, vo, hi, ho, ew, eok, eerr, eovf);
    @(negedge clk);
    v_in = SW'(vi); v_out = SW'(vo); h_in = SW'(hi); h_out = SW'(ho);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " busy after start (R9)"}, longint'(busy), 1);
    wait_done(req);
    chk({req, " word"}, longint'(rsz_word), ew);
    chk({req, " word_ok"}, longint'(word_ok), longint'(eok));
    chk({req, " err"}, longint'(err), longint'(eerr));
    chk({req, " ovf"}, longint'(ovf), longint'(eovf));
    @(negedge clk);
    chk({req, " done one cycle (R9)"}, longint'(done), 0);
    chk({req, " busy low after done (R9)"}, longint'(busy), 0);
  endtask

  task automatic t_reset;
    chk("R11 busy", longint'(busy), 0);
    chk("R11 done", longint'(done), 0);
    chk("R11 word_ok", longint'(word_ok), 0);
    chk("R11 err", longint'(err), 0);
    chk("R11 ovf", longint'(ovf), 0);
    chk("R11 word", longint'(rsz_word), 0);
  endtask

  task automatic t_limits;
    run_case("R1 source above 4096", 5000, 1024, 100, 100);
    run_case("R1 target above 1024", 1025, 1025, 100, 100);
    run_case("R1 limits exact 4096/1024", 4096, 1024, 1024, 1024);
    run_case("R8 horizontal illegal only", 100, 100, 1025, 1025);
  endtask

  task automatic t_ratio;
    run_case("R2 just past 4:1", 401, 100, 100, 100);
    run_case("R2 exactly 4:1", 400, 100, 100, 100);
  endtask

  task automatic t_small;
    run_case("R3 target of 1", 5, 1, 100, 100);
    run_case("R3 source of 0", 0, 50, 100, 100);
    run_case("R3 target of 2", 2, 2, 3, 2);
  endtask

  task automatic t_downsize;
    run_case("R4 two halvings capped", 3000, 1000, 4000, 1000);
    run_case("R4 one halving", 300, 150, 640, 320);
  endtask

  task automatic t_coef;
    run_case("R5 upscale ratio", 100, 400, 33, 1000);
    run_case("R6 clamp on vertical", 199, 100, 100, 100);
    run_case("R6 clamp on horizontal", 64, 64, 199, 100);
    run_case("R7 field packing", 100, 400, 4096, 1024);
  endtask

  task automatic t_busy_ignore;
    longint ew;
    bit eok, eerr, eovf;
    int quiet = 0;
    expect_all(100, 400, 720, 480, ew, eok, eerr, eovf);
    @(negedge clk);
    v_in = 13'd100; v_out = 13'd400; h_in = 13'd720; h_out = 13'd480;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    v_in = 13'd50; v_out = 13'd60; h_in = 13'd5000; h_out = 13'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R10");
    chk("R10 word uses first sizes", longint'(rsz_word), ew);
    chk("R10 err uses first sizes", longint'(err), longint'(eerr));
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (done || busy) quiet++;
    end
    chk("R10 no queued run after mid-run start", longint'(quiet), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    v_in = '0; v_out = '0; h_in = '0; h_out = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_limits();
    t_ratio();
    t_small();
    t_downsize();
    t_coef();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule